// File: doc/BRIEF.md
# Resolver Amplitude Fault Monitor

This block supervises the health of the excitation-derived resolver signals. It receives a stream of digitized monitor magnitudes, each marked by a valid strobe. Over a fixed observation window it keeps a running lowest and highest magnitude. When a window closes, it compares those two extremes against three programmable limits. A magnitude below the loss limit is reported as signal loss. A magnitude above the overrange limit, or a spread between highest and lowest that is wider than the mismatch limit, is reported as signal degradation.

The window length is counted in internal ticks, and the block derives one tick from every second clock edge. A two-bit range field selects the window length so that it matches the excitation frequency band in use. Each fault sets a sticky bit in a three-bit fault register. The two active-low fault pins follow those bits. A bit stays set until software reads the fault register while configuration mode is active. If the fault condition persists, the bit returns at the next window boundary.

Configuration uses a small write port with a 3-bit address. Each register is written with a single-cycle strobe.

Top module: `amp_fault_mon`

## Requirements
- R1: An internal tick occurs on every second clock edge. A window lasts a number of ticks chosen by the range field: 1065 for value 0, 554 for value 1, and 256 for values 2 and 3. A window therefore spans exactly twice that many clock cycles. Writing the range register restarts the window count, the tick phase and the running extremes.
- R2: At the start of each window, the running minimum loads the minimum seed and the running maximum loads the maximum seed. Every sample presented with the valid strobe high is folded into both extremes, including a sample on the cycle that closes the window. Cycles with the valid strobe low have no effect.
- R3: When a window closes with its minimum strictly below the loss threshold, fault bit 0 (signal loss) is set.
- R4: When a window closes with its maximum strictly above the overrange threshold, fault bit 1 (overrange) is set.
- R5: When a window closes with maximum minus minimum strictly greater than the mismatch threshold, fault bit 2 (mismatch) is set. The spread counts as zero when the maximum does not exceed the minimum.
- R6: Fault bits become set only on the clock edge that closes a window, and they are visible from the following cycle. Once set, a bit stays set until it is cleared.
- R7: Pulsing the read strobe while configuration mode is high clears all three fault bits. A read strobe with configuration mode low has no effect. If a clear and a window close fall on the same edge, the clear removes the old bits and the new window's results are still set.
- R8: The loss pin is low exactly when fault bit 0 is set. The degradation pin is low exactly when fault bit 1 or fault bit 2 is set.
- R9: The register addresses are: 0 loss threshold, 1 overrange threshold, 2 mismatch threshold, 3 minimum seed, 4 maximum seed, 5 range field (data bits 1:0). Any other address is ignored. Reset loads the following values: loss threshold 0, overrange threshold all ones, mismatch threshold all ones, minimum seed all ones, maximum seed 0, range 2. Reset also clears the fault register, and the first window starts at reset release.
- R10: If a fault condition is still present after a clear, its bit is set again at the first window boundary after the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; the internal tick runs at half its rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Marks a valid monitor magnitude this cycle |
| smp_mag | input | MAG_W | Monitor magnitude sample |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_addr | input | 3 | Configuration register address |
| cfg_wdata | input | MAG_W | Configuration write data |
| cfg_mode | input | 1 | Configuration mode; a fault read clears only while this is high |
| flt_rd | input | 1 | Fault register read strobe |
| fault_reg | output | 3 | Sticky fault bits {mismatch, overrange, loss} |
| los_n | output | 1 | Active-low signal-loss pin |
| dos_n | output | 1 | Active-low signal-degradation pin |

## Verification
The bench sweeps pairs of sample values placed around every threshold. Values equal to a limit catch a design that uses a non-strict comparison, and a spread exactly one over the mismatch limit catches a wrong comparison direction. Each window is checked one cycle before it closes and one cycle after, so a window counter that is one tick short or one tick long, or that runs at full clock rate, shows up as a flag that appears early or late. The last sample of each window arrives on the closing cycle, and idle cycles carry a zero magnitude. A design that drops the closing sample, or that absorbs unqualified samples, therefore reports the wrong loss bit. A further sequence checks three things: a read outside configuration mode must leave the bits alone, a clear that coincides with a window close must keep the new result, and a persistent fault must come back one window after it is cleared.

// File: rtl/afm_pkg.sv
package afm_pkg;

  // configuration register addresses
  localparam logic [2:0] ADDR_THR_LOS  = 3'd0;
  localparam logic [2:0] ADDR_THR_OVR  = 3'd1;
  localparam logic [2:0] ADDR_THR_MISM = 3'd2;
  localparam logic [2:0] ADDR_SEED_MIN = 3'd3;
  localparam logic [2:0] ADDR_SEED_MAX = 3'd4;
  localparam logic [2:0] ADDR_RANGE    = 3'd5;

  localparam logic [1:0] RANGE_RESET = 2'd2;

  // sticky fault bits, LSB is loss
  typedef struct packed {
    logic mism;
    logic ovr;
    logic los;
  } flt_t;

  // window length in ticks for a range code
  function automatic int unsigned pick_len(input logic [1:0] sel,
                                           input int unsigned slow,
                                           input int unsigned mid,
                                           input int unsigned fast);
    case (sel)
      2'd0:    return slow;
      2'd1:    return mid;
      default: return fast;
    endcase
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/afm_winctl.sv
module afm_winctl #(
  parameter int unsigned LEN_SLOW = 1065,
  parameter int unsigned LEN_MID  = 554,
  parameter int unsigned LEN_FAST = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       tick,
  output logic       win_end
);

  localparam int unsigned LEN_MAX = afm_pkg::max3(LEN_SLOW, LEN_MID, LEN_FAST);
  localparam int unsigned CNT_W   = $clog2(LEN_MAX);

  logic             phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_idx;

  always_comb begin
    last_idx = CNT_W'(afm_pkg::pick_len(sel, LEN_SLOW, LEN_MID, LEN_FAST) - 1);
    tick     = phase_q;
    win_end  = phase_q && (cnt_q == last_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else if (restart) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      phase_q <= ~phase_q;
      if (tick) begin
        cnt_q <= win_end ? '0 : cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/afm_extrema.sv
module afm_extrema #(
  parameter int MAG_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic             win_end,
  input  logic             smp_vld,
  input  logic [MAG_W-1:0] smp_mag,
  input  logic [MAG_W-1:0] seed_min,
  input  logic [MAG_W-1:0] seed_max,
  output logic [MAG_W-1:0] cand_min,
  output logic [MAG_W-1:0] cand_max,
  output logic [MAG_W-1:0] run_min,
  output logic [MAG_W-1:0] run_max
);

  function automatic logic [MAG_W-1:0] lower(input logic [MAG_W-1:0] a,
                                             input logic [MAG_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [MAG_W-1:0] higher(input logic [MAG_W-1:0] a,
                                              input logic [MAG_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  // extremes including this cycle's sample
  always_comb begin
    cand_min = smp_vld ? lower(run_min, smp_mag)  : run_min;
    cand_max = smp_vld ? higher(run_max, smp_mag) : run_max;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_min <= '1;
      run_max <= '0;
    end else if (reload || win_end) begin
      run_min <= seed_min;
      run_max <= seed_max;
    end else begin
      run_min <= cand_min;
      run_max <= cand_max;
    end
  end

endmodule

// File: rtl/afm_judge.sv
module afm_judge #(
  parameter int MAG_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_end,
  input  logic              clr_req,
  input  logic [MAG_W-1:0]  cand_min,
  input  logic [MAG_W-1:0]  cand_max,
  input  logic [MAG_W-1:0]  thr_los,
  input  logic [MAG_W-1:0]  thr_ovr,
  input  logic [MAG_W-1:0]  thr_mism,
  output afm_pkg::flt_t     win_hits,
  output afm_pkg::flt_t     flt_q
);

  function automatic logic [MAG_W-1:0] spread(input logic [MAG_W-1:0] mx,
                                               input logic [MAG_W-1:0] mn);
    return (mx > mn) ? (mx - mn) : '0;
  endfunction

  afm_pkg::flt_t kept;

  always_comb begin
    win_hits.los  = cand_min < thr_los;
    win_hits.ovr  = cand_max > thr_ovr;
    win_hits.mism = spread(cand_max, cand_min) > thr_mism;
    kept          = clr_req ? afm_pkg::flt_t'('0) : flt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q <= '0;
    end else if (win_end) begin
      flt_q <= kept | win_hits;
    end else begin
      flt_q <= kept;
    end
  end

endmodule

// File: rtl/amp_fault_mon.sv
module amp_fault_mon #(
  parameter int MAG_W    = 12,
  parameter int LEN_SLOW = 1065,
  parameter int LEN_MID  = 554,
  parameter int LEN_FAST = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld,
  input  logic [MAG_W-1:0] smp_mag,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [MAG_W-1:0] cfg_wdata,
  input  logic             cfg_mode,
  input  logic             flt_rd,
  output logic [2:0]       fault_reg,
  output logic             los_n,
  output logic             dos_n
);

  logic [MAG_W-1:0] thr_los_q, thr_ovr_q, thr_mism_q;
  logic [MAG_W-1:0] seed_min_q, seed_max_q;
  logic [1:0]       rng_q;

  // named internal events
  logic             restart;
  logic             clr_req;
  logic             tick;
  logic             win_end;
  logic [MAG_W-1:0] cand_min, cand_max, run_min, run_max;
  afm_pkg::flt_t    win_hits;
  afm_pkg::flt_t    flt_q;

  assign restart = cfg_we && (cfg_addr == afm_pkg::ADDR_RANGE);
  assign clr_req = flt_rd && cfg_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_los_q  <= '0;
      thr_ovr_q  <= '1;
      thr_mism_q <= '1;
      seed_min_q <= '1;
      seed_max_q <= '0;
      rng_q      <= afm_pkg::RANGE_RESET;
    end else if (cfg_we) begin
      case (cfg_addr)
        afm_pkg::ADDR_THR_LOS:  thr_los_q  <= cfg_wdata;
        afm_pkg::ADDR_THR_OVR:  thr_ovr_q  <= cfg_wdata;
        afm_pkg::ADDR_THR_MISM: thr_mism_q <= cfg_wdata;
        afm_pkg::ADDR_SEED_MIN: seed_min_q <= cfg_wdata;
        afm_pkg::ADDR_SEED_MAX: seed_max_q <= cfg_wdata;
        afm_pkg::ADDR_RANGE:    rng_q      <= cfg_wdata[1:0];
        default: ;
      endcase
    end
  end

  afm_winctl #(
    .LEN_SLOW (LEN_SLOW),
    .LEN_MID  (LEN_MID),
    .LEN_FAST (LEN_FAST)
  ) winctl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .sel     (restart ? cfg_wdata[1:0] : rng_q),
    .tick    (tick),
    .win_end (win_end)
  );

  afm_extrema #(.MAG_W(MAG_W)) extrema_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reload   (restart),
    .win_end  (win_end),
    .smp_vld  (smp_vld),
    .smp_mag  (smp_mag),
    .seed_min (seed_min_q),
    .seed_max (seed_max_q),
    .cand_min (cand_min),
    .cand_max (cand_max),
    .run_min  (run_min),
    .run_max  (run_max)
  );

  afm_judge #(.MAG_W(MAG_W)) judge_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_end  (win_end),
    .clr_req  (clr_req),
    .cand_min (cand_min),
    .cand_max (cand_max),
    .thr_los  (thr_los_q),
    .thr_ovr  (thr_ovr_q),
    .thr_mism (thr_mism_q),
    .win_hits (win_hits),
    .flt_q    (flt_q)
  );

  assign fault_reg = flt_q;
  assign los_n     = ~flt_q.los;
  assign dos_n     = ~(flt_q.ovr | flt_q.mism);

endmodule

// File: rtl/afm_chk.sv
module afm_chk #(
  parameter int MAG_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             win_end,
  input logic             restart,
  input logic             clr_req,
  input logic [MAG_W-1:0] seed_min,
  input logic [MAG_W-1:0] seed_max,
  input logic [MAG_W-1:0] run_min,
  input logic [MAG_W-1:0] run_max,
  input logic [2:0]       win_hits,
  input logic [2:0]       fault_reg
);

  AST_TICK_HALF_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart) |=> !tick); // R1

  AST_END_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |-> tick); // R1

  AST_RELOAD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (run_min == $past(seed_min))); // R2

  AST_RELOAD_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (run_max == $past(seed_max))); // R2

  AST_LOS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && win_hits[0]) |=> fault_reg[0]); // R3

  AST_OVR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && win_hits[1]) |=> fault_reg[1]); // R4

  AST_MISM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && win_hits[2]) |=> fault_reg[2]); // R5

  AST_NO_MIDWIN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> ((fault_reg & ~$past(fault_reg)) == 3'b000)); // R6

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_req |=> ((fault_reg & $past(fault_reg)) == $past(fault_reg))); // R6

  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !win_end) |=> (fault_reg == 3'b000)); // R7

endmodule

bind amp_fault_mon afm_chk #(.MAG_W(MAG_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .win_end   (win_end),
  .restart   (restart),
  .clr_req   (clr_req),
  .seed_min  (seed_min_q),
  .seed_max  (seed_max_q),
  .run_min   (run_min),
  .run_max   (run_max),
  .win_hits  (win_hits),
  .fault_reg (fault_reg)
);

// File: tb/amp_fault_mon_tb_top.sv
module amp_fault_mon_tb_top;

  localparam int MAG_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             smp_vld = 1'b0;
  logic [MAG_W-1:0] smp_mag = '0;
  logic             cfg_we = 1'b0;
  logic [2:0]       cfg_addr = '0;
  logic [MAG_W-1:0] cfg_wdata = '0;
  logic             cfg_mode = 1'b0;
  logic             flt_rd = 1'b0;
  logic [2:0]       fault_reg;
  logic             los_n, dos_n;

  int n_chk = 0;
  int n_err = 0;

  // bench copy of the programmed settings
  int m_los = 0, m_ovr = 4095, m_mism = 4095, m_smin = 4095, m_smax = 0;

  always #2 clk = ~clk;

  amp_fault_mon #(.MAG_W(MAG_W)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_vld   (smp_vld),
    .smp_mag   (smp_mag),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_mode  (cfg_mode),
    .flt_rd    (flt_rd),
    .fault_reg (fault_reg),
    .los_n     (los_n),
    .dos_n     (dos_n)
  );

  // expected fault bits of one window holding samples a and b
  function automatic logic [2:0] model(input int a, input int b);
    int mn, mx;
    logic [2:0] r;
    mn = m_smin; mx = m_smax;
    if (a < mn) mn = a;
    if (b < mn) mn = b;
    if (a > mx) mx = a;
    if (b > mx) mx = b;
    r[0] = mn < m_los;
    r[1] = mx > m_ovr;
    r[2] = (mx > mn) && ((mx - mn) > m_mism);
    return r;
  endfunction

  // fault bits and both pins (pins per R8)
  task automatic chk(input string req, input logic [2:0] exp);
    logic el, ed;
    el = ~exp[0];
    ed = ~(exp[1] | exp[2]);
    n_chk++;
    if (fault_reg !== exp || los_n !== el || dos_n !== ed) begin
      n_err++;
      $display("FAIL %s/R8: fault=%b los_n=%b dos_n=%b, expected fault=%b los_n=%b dos_n=%b",
               req, fault_reg, los_n, dos_n, exp, el, ed);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [2:0] a, input int d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = MAG_W'(d);
    step();
    cfg_we = 1'b0;
  endtask

  // range write restarts the window; a read in config mode clears faults
  task automatic restart(input int sel);
    flt_rd = 1'b1; cfg_mode = 1'b1;
    cfg_write(3'd5, sel);
    flt_rd = 1'b0; cfg_mode = 1'b0;
  endtask

  // one window of len2 clock cycles; samples at cycles 3, 100 and the last one
  task automatic run_win(input int len2, input int a, input int b,
                         input int rd_k, input bit rd_mode,
                         input logic [2:0] pre, input logic [2:0] post,
                         input string req);
    for (int k = 1; k <= len2; k++) begin
      smp_vld  = (k == 3) || (k == 100) || (k == len2);
      smp_mag  = (k == 3) ? MAG_W'(a) :
                 (k == 100) ? MAG_W'((a + b) / 2) :
                 (k == len2) ? MAG_W'(b) : '0;
      flt_rd   = (k == rd_k);
      cfg_mode = (k == rd_k) && rd_mode;
      if (k == len2) chk({req, " pre-boundary"}, pre);
      step();
    end
    smp_vld = 1'b0; smp_mag = '0; flt_rd = 1'b0; cfg_mode = 1'b0;
    chk({req, " post-boundary"}, post);
  endtask

  task automatic run_all();
    int vals[8] = '{100, 399, 400, 1000, 1400, 2000, 3000, 3001};
    repeat (3) step();
    chk("R9 reset state", 3'b000);
    rst_n = 1'b1;
    // R9: default limits flag nothing, default range gives 512-cycle window
    run_win(512, 0, 4095, 0, 1'b0, 3'b000, 3'b000, "R9 defaults");

    cfg_write(3'd0, 400);  m_los  = 400;
    cfg_write(3'd1, 3000); m_ovr  = 3000;
    cfg_write(3'd2, 1000); m_mism = 1000;
    cfg_write(3'd3, 4095); m_smin = 4095;
    cfg_write(3'd4, 0);    m_smax = 0;
    cfg_write(3'd7, 5);    // unmapped address, ignored (R9)

    // R3 R4 R5 sweep around every limit
    foreach (vals[i]) begin
      foreach (vals[j]) begin
        restart(2);
        run_win(512, vals[i], vals[j], 0, 1'b0, 3'b000,
                model(vals[i], vals[j]), "R3/R4/R5 sweep");
      end
    end

    // R2 seeds take part in the window extremes
    cfg_write(3'd3, 300); m_smin = 300;
    restart(2);
    run_win(512, 2000, 2000, 0, 1'b0, 3'b000, model(2000, 2000), "R2 min seed");
    cfg_write(3'd3, 4095); m_smin = 4095;
    cfg_write(3'd4, 3500); m_smax = 3500;
    restart(2);
    run_win(512, 2000, 2000, 0, 1'b0, 3'b000, model(2000, 2000), "R2 max seed");
    cfg_write(3'd4, 0); m_smax = 0;

    // R1 window lengths per range code
    restart(0);
    run_win(2130, 100, 100, 0, 1'b0, 3'b000, 3'b001, "R1 range0");
    restart(1);
    run_win(1108, 100, 100, 0, 1'b0, 3'b000, 3'b001, "R1 range1");
    restart(3);
    run_win(512, 100, 100, 0, 1'b0, 3'b000, 3'b001, "R1 range3");

    // R6 R7 R10 stickiness and clearing, windows back to back
    restart(2);
    run_win(512, 100, 2000, 0, 1'b0, 3'b000, 3'b101, "R6 set");
    run_win(512, 2000, 2000, 50, 1'b0, 3'b101, 3'b101, "R7 read outside config mode");
    run_win(512, 100, 100, 512, 1'b1, 3'b101, 3'b001, "R7 clear at boundary");
    run_win(512, 100, 100, 50, 1'b1, 3'b000, 3'b001, "R10 persistent fault");
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule